// File: doc/BRIEF.md
# Scan Chain Toggle Activity Monitor

This block watches one scan chain while patterns are shifted in and responses are captured, and it measures switching activity in the chain's flip-flops. On every chain clock it compares the chain's parallel state with the state one cycle earlier. It sorts the toggles into those caused by incoming pattern bits (shift-in), those caused by the outgoing response (shift-out) and those caused by a capture clock. It keeps a saturating running total for each class, a grand total, and the largest number of toggles seen in any single chain clock.

Before a pattern is shifted, the block also predicts how many shift-in toggles it will cause. It does not take the Hamming distance for this. It weights each adjacent bit change in the pattern by how far that change travels along the chain. A test controller can read the prediction to choose or reorder patterns. A one-cycle pulse marks the end of each load, once the configured number of shift clocks has been counted.

Top module: `scan_activity_mon`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, the following are all zero: `shin_cnt`, `shout_cnt`, `cap_cnt`, `total_cnt`, `peak_cnt` and `done`. The shift index also restarts.
- R2: `pred_shin` is registered with one cycle of latency. With cell 0 at the scan-in end and `next_pat[i]` the value cell i holds after the load, `pred_shin` equals W1 + W2. W1 is N when `chain_q[0]` differs from `next_pat[N-1]`, and 0 otherwise. W2 is the sum of (j+1) over every j in 0..N-2 where `next_pat[j+1]` differs from `next_pat[j]`. Example: a 4-cell chain at 0000 loading `4'b1010` gives 10.
- R3: A shift clock is a cycle with `shift_stb` and `scan_en` both high. Let s be that clock's ordinal since `scan_en` went high, counting from 1 and saturating at N. On that shift clock, toggles in cells with index below s add to `shin_cnt`. The chain moves toward higher index, with cell 0 loaded from scan-in. Over a full N-shift load, `shin_cnt` grows by exactly the R2 value.
- R4: On a shift clock, toggles in cells with index s or higher add to `shout_cnt`. Over a full load from state c, `shout_cnt` grows by the sum of (N-j) over every j in 1..N-1 where `c[j]` differs from `c[j-1]`.
- R5: A capture clock is a cycle with `shift_stb` high and `scan_en` low. It adds the Hamming distance between the previous and the present `chain_q` to `cap_cnt`, and it leaves `shin_cnt` and `shout_cnt` unchanged.
- R6: `total_cnt` accumulates the per-clock toggle count of every shift and capture clock.
- R7: `peak_cnt` holds the largest per-clock toggle count since the last reset or clear. It never exceeds N.
- R8: Every counter stops at its all-ones value instead of wrapping. It never decreases except on clear.
- R9: `done` is high for exactly one cycle, in the cycle after the SHIFT_LEN-th shift clock since `scan_en` rose. It is low after every other shift clock.
- R10: Cycles with `shift_stb` low change no counter and do not change `peak_cnt`, whatever `next_pat` does.
- R11: All counters and `peak_cnt` update at the clock edge that ends the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, peak and shift index |
| scan_en | input | 1 | High: chain is in shift mode; low: capture mode |
| shift_stb | input | 1 | Chain clock occurred; `chain_q` shows the new state |
| chain_q | input | N | Parallel state of the chain, bit 0 nearest scan-in |
| next_pat | input | N | Pattern to be loaded next, bit i = final value of cell i |
| pred_shin | output | clog2(N(N+1)/2+1) | Predicted shift-in toggles for `next_pat` |
| shin_cnt | output | CNT_W | Saturating shift-in toggle total |
| shout_cnt | output | CNT_W | Saturating shift-out toggle total |
| cap_cnt | output | CNT_W | Saturating capture toggle total |
| total_cnt | output | CNT_W | Saturating total of all per-clock toggles |
| peak_cnt | output | clog2(N+1) | Largest per-clock toggle count |
| done | output | 1 | One-cycle pulse after SHIFT_LEN shift clocks |

## Verification
The assertions assume three things about the inputs. First, `chain_q` changes only in cycles where `shift_stb` is high. Second, in shift mode it moves by exactly one cell toward higher index. Third, `scan_en` drops between loads so the shift ordinal restarts. The bench keeps to these rules by holding a model of the chain and driving it only together with the strobe. It starts each load from a cycle with `scan_en` high and no strobe, and it lowers `scan_en` for every capture. Random patterns and responses are combined with checkerboard and constant loads. These drive the counters into saturation and push the per-clock peak to its limit.

// File: rtl/scan_act_pkg.sv
package scan_act_pkg;

  typedef enum logic [1:0] {
    EV_IDLE    = 2'd0,
    EV_SHIFT   = 2'd1,
    EV_CAPTURE = 2'd2
  } ev_kind_t;

  localparam int NUM_CTR   = 4;
  localparam int CTR_SHIN  = 0;
  localparam int CTR_SHOUT = 1;
  localparam int CTR_CAP   = 2;
  localparam int CTR_TOTAL = 3;

endpackage

// File: rtl/sam_toggle_split.sv
// Splits the toggles of one chain clock into incoming-pattern and
// outgoing-response parts using the shift ordinal.
module sam_toggle_split #(
  parameter int N  = 8,
  parameter int IW = 4,
  parameter int CW = 4
) (
  input  logic [N-1:0]  delta,
  input  logic [IW-1:0] shift_ord,
  output logic [CW-1:0] in_n,
  output logic [CW-1:0] out_n,
  output logic [CW-1:0] all_n
);

  logic [N-1:0] in_mask;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign in_mask[g] = (shift_ord > IW'(g));
  end

  function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < N; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  assign in_n  = ones(delta & in_mask);
  assign out_n = ones(delta & ~in_mask);
  assign all_n = ones(delta);

endmodule

// File: rtl/sam_predict.sv
// Weighted shift-in toggle estimate for the next pattern.
module sam_predict #(
  parameter int N  = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pat,
  input  logic          head,
  output logic [PW-1:0] pred
);

  function automatic logic [PW-1:0] weigh(input logic [N-1:0] p, input logic h);
    logic [PW-1:0] acc;
    acc = (h != p[N-1]) ? PW'(N) : '0;
    for (int j = 0; j < N - 1; j++) begin
      if (p[j+1] != p[j]) acc = acc + PW'(j + 1);
    end
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred <= '0;
    else        pred <= weigh(pat, head);
  end

endmodule

// File: rtl/sam_sat_acc.sv
// Saturating accumulator with synchronous clear.
module sam_sat_acc #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  q
);

  localparam int SW = W + 1;

  logic [SW-1:0] sum;
  logic [W-1:0]  q_nxt;

  always_comb begin
    sum   = {1'b0, q} + SW'(inc);
    q_nxt = sum[W] ? '1 : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q_nxt;
  end

endmodule

// File: rtl/sam_peak_hold.sv
// Keeps the largest sample seen since clear.
module sam_peak_hold #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] sample,
  output logic [CW-1:0] peak
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   peak <= '0;
    else if (clr)                 peak <= '0;
    else if (en && sample > peak) peak <= sample;
  end

endmodule

// File: rtl/scan_activity_mon.sv
module scan_activity_mon
  import scan_act_pkg::*;
#(
  parameter int N         = 8,
  parameter int CNT_W     = 16,
  parameter int SHIFT_LEN = N,
  localparam int IW = $clog2(N + 1),
  localparam int CW = $clog2(N + 1),
  localparam int PW = $clog2(N * (N + 1) / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             scan_en,
  input  logic             shift_stb,
  input  logic [N-1:0]     chain_q,
  input  logic [N-1:0]     next_pat,
  output logic [PW-1:0]    pred_shin,
  output logic [CNT_W-1:0] shin_cnt,
  output logic [CNT_W-1:0] shout_cnt,
  output logic [CNT_W-1:0] cap_cnt,
  output logic [CNT_W-1:0] total_cnt,
  output logic [CW-1:0]    peak_cnt,
  output logic             done
);

  // Previous chain state and per-clock difference.
  logic [N-1:0]  prev_q;
  logic [N-1:0]  delta;
  logic [IW-1:0] ord_q;
  logic [IW-1:0] shift_ord;
  ev_kind_t      ev;
  logic          shift_ev;
  logic          cap_ev;
  logic [CW-1:0] in_n, out_n, all_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q;
  end

  assign delta = chain_q ^ prev_q;

  always_comb begin
    if (!shift_stb)   ev = EV_IDLE;
    else if (scan_en) ev = EV_SHIFT;
    else              ev = EV_CAPTURE;
  end

  assign shift_ev = (ev == EV_SHIFT);
  assign cap_ev   = (ev == EV_CAPTURE);

  // Shift ordinal: number of shift clocks since scan_en rose, saturating at N.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ord_q <= '0;
    else if (clr || !scan_en)             ord_q <= '0;
    else if (shift_ev && ord_q < IW'(N))  ord_q <= ord_q + 1'b1;
  end

  // Ordinal of the shift happening in this cycle.
  assign shift_ord = (ord_q < IW'(N)) ? ord_q + 1'b1 : ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= !clr && shift_ev && (ord_q == IW'(SHIFT_LEN - 1));
  end

  sam_toggle_split #(.N(N), .IW(IW), .CW(CW)) u_split (
    .delta     (delta),
    .shift_ord (shift_ord),
    .in_n      (in_n),
    .out_n     (out_n),
    .all_n     (all_n)
  );

  sam_predict #(.N(N), .PW(PW)) u_pred (
    .clk   (clk),
    .rst_n (rst_n),
    .pat   (next_pat),
    .head  (chain_q[0]),
    .pred  (pred_shin)
  );

  // Counter bank.
  logic [CW-1:0]    ctr_inc [NUM_CTR];
  logic             ctr_en  [NUM_CTR];
  logic [CNT_W-1:0] ctr_q   [NUM_CTR];

  always_comb begin
    ctr_inc[CTR_SHIN]  = in_n;
    ctr_en [CTR_SHIN]  = shift_ev;
    ctr_inc[CTR_SHOUT] = out_n;
    ctr_en [CTR_SHOUT] = shift_ev;
    ctr_inc[CTR_CAP]   = all_n;
    ctr_en [CTR_CAP]   = cap_ev;
    ctr_inc[CTR_TOTAL] = all_n;
    ctr_en [CTR_TOTAL] = shift_ev || cap_ev;
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    sam_sat_acc #(.W(CNT_W), .IW(CW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (ctr_en[k]),
      .inc   (ctr_inc[k]),
      .q     (ctr_q[k])
    );
  end

  assign shin_cnt  = ctr_q[CTR_SHIN];
  assign shout_cnt = ctr_q[CTR_SHOUT];
  assign cap_cnt   = ctr_q[CTR_CAP];
  assign total_cnt = ctr_q[CTR_TOTAL];

  sam_peak_hold #(.CW(CW)) u_peak (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (shift_ev || cap_ev),
    .sample (all_n),
    .peak   (peak_cnt)
  );

endmodule

// File: rtl/scan_activity_mon_chk.sv
module scan_activity_mon_chk #(
  parameter int N     = 8,
  parameter int CNT_W = 16,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             shift_stb,
  input logic             shift_ev,
  input logic             cap_ev,
  input logic [CNT_W-1:0] shin_cnt,
  input logic [CNT_W-1:0] shout_cnt,
  input logic [CNT_W-1:0] cap_cnt,
  input logic [CNT_W-1:0] total_cnt,
  input logic [CW-1:0]    peak_cnt,
  input logic             done
);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (shin_cnt == '0 && shout_cnt == '0 && cap_cnt == '0 &&
             total_cnt == '0 && peak_cnt == '0 && !done));

  p_shift_no_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !clr) |=> $stable(cap_cnt));

  p_capture_keeps_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && !clr) |=> ($stable(shin_cnt) && $stable(shout_cnt)));

  p_peak_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(peak_cnt) <= N);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (shin_cnt >= $past(shin_cnt) && shout_cnt >= $past(shout_cnt) &&
              cap_cnt >= $past(cap_cnt) && total_cnt >= $past(total_cnt) &&
              peak_cnt >= $past(peak_cnt)));

  p_done_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(shift_ev && !clr));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_stb && !clr) |=> ($stable(total_cnt) && $stable(cap_cnt) &&
                              $stable(shin_cnt) && $stable(shout_cnt) &&
                              $stable(peak_cnt)));

endmodule

bind scan_activity_mon scan_activity_mon_chk #(.N(N), .CNT_W(CNT_W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .shift_stb (shift_stb),
  .shift_ev  (shift_ev),
  .cap_ev    (cap_ev),
  .shin_cnt  (shin_cnt),
  .shout_cnt (shout_cnt),
  .cap_cnt   (cap_cnt),
  .total_cnt (total_cnt),
  .peak_cnt  (peak_cnt),
  .done      (done)
);

// File: tb/test_scan_activity_mon.sv
module test_scan_activity_mon;

  localparam int N     = 8;
  localparam int CNT_W = 8;
  localparam int CW    = $clog2(N + 1);
  localparam int PW    = $clog2(N * (N + 1) / 2 + 1);
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n, clr, scan_en, shift_stb;
  logic [N-1:0]     chain_q, next_pat;
  logic [PW-1:0]    pred_shin;
  logic [CNT_W-1:0] shin_cnt, shout_cnt, cap_cnt, total_cnt;
  logic [CW-1:0]    peak_cnt;
  logic             done;

  always #5 clk = ~clk;

  scan_activity_mon #(.N(N), .CNT_W(CNT_W), .SHIFT_LEN(N)) i_scan_activity_mon (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .shift_stb(shift_stb),
    .chain_q(chain_q), .next_pat(next_pat), .pred_shin(pred_shin),
    .shin_cnt(shin_cnt), .shout_cnt(shout_cnt), .cap_cnt(cap_cnt),
    .total_cnt(total_cnt), .peak_cnt(peak_cnt), .done(done)
  );

  int nchk = 0, nfail = 0;
  int e_in = 0, e_out = 0, e_cap = 0, e_tot = 0, e_peak = 0;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entry-order walk: each newly entering bit compared with its predecessor.
  function automatic int bp_in(input logic [N-1:0] p, input logic head);
    int w = 0;
    logic prv = head;
    for (int k = 1; k <= N; k++) begin
      if (p[N-k] != prv) w += N - k + 1;
      prv = p[N-k];
    end
    return w;
  endfunction

  // Response changes weighted by distance from scan-out.
  function automatic int bp_out(input logic [N-1:0] c);
    int w = 0;
    for (int pos = 1; pos < N; pos++)
      if (c[N-pos] != c[N-pos-1]) w += pos;
    return w;
  endfunction

  function automatic int hamm(input logic [N-1:0] a, input logic [N-1:0] b);
    int h = 0;
    for (int i = 0; i < N; i++) if (a[i] != b[i]) h++;
    return h;
  endfunction

  function automatic int sat(input int a, input int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic check_ctrs(input string tag);
    check({"R3 shin ", tag},  int'(shin_cnt),  e_in);
    check({"R4 shout ", tag}, int'(shout_cnt), e_out);
    check({"R5 cap ", tag},   int'(cap_cnt),   e_cap);
    check({"R6 total ", tag}, int'(total_cnt), e_tot);
    check({"R7 peak ", tag},  int'(peak_cnt),  e_peak);
  endtask

  // Time is at a negedge on entry and on exit.
  task automatic do_load(input logic [N-1:0] p);
    int h;
    next_pat = p;
    @(negedge clk);
    check("R2 prediction", int'(pred_shin), bp_in(p, chain_q[0]));
    e_in  = sat(e_in, bp_in(p, chain_q[0]));
    e_out = sat(e_out, bp_out(chain_q));
    scan_en = 1'b1;
    for (int s = 1; s <= N; s++) begin
      @(negedge clk);
      if (s >= 2) check("R9 done low mid-load", int'(done), 0);
      h = hamm(chain_q, {chain_q[N-2:0], p[N-s]});
      chain_q   = {chain_q[N-2:0], p[N-s]};
      shift_stb = 1'b1;
      e_tot = sat(e_tot, h);
      if (h > e_peak) e_peak = h;
    end
    @(negedge clk);
    check("R9 done pulse", int'(done), 1);
    check_ctrs("after load R11");
    shift_stb = 1'b0;
    scan_en   = 1'b0;
    @(negedge clk);
    check("R9 done one cycle", int'(done), 0);
  endtask

  task automatic do_capture(input logic [N-1:0] r);
    int h;
    h = hamm(chain_q, r);
    chain_q   = r;
    scan_en   = 1'b0;
    shift_stb = 1'b1;
    e_cap = sat(e_cap, h);
    e_tot = sat(e_tot, h);
    if (h > e_peak) e_peak = h;
    @(negedge clk);
    shift_stb = 1'b0;
    check_ctrs("after capture");
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    e_in = 0; e_out = 0; e_cap = 0; e_tot = 0; e_peak = 0;
    check_ctrs("R1 clear");
    check("R1 done after clear", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; clr = 1'b0; scan_en = 1'b0; shift_stb = 1'b0;
    chain_q = '0; next_pat = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_ctrs("R1 reset");
    check("R1 done reset", int'(done), 0);

    // Prediction corner cases.
    next_pat = 8'b1010_1010;
    @(negedge clk);
    check("R2 checkerboard max", int'(pred_shin), 36);
    next_pat = 8'h00;
    @(negedge clk);
    check("R2 all-equal zero", int'(pred_shin), 0);
    next_pat = 8'h80;
    @(negedge clk);
    check("R2 single head change", int'(pred_shin), 15);

    do_load(8'b1010_1010);
    check("R3 checkerboard shin", int'(shin_cnt), 36);
    do_capture(8'hFF);
    do_load(8'h00);
    do_capture(8'b0101_0101);
    do_load(8'h0F);
    check("R7 peak reaches N", int'(peak_cnt), N);

    // R10: no strobe, next_pat wiggles, counters stay put.
    for (int i = 0; i < 6; i++) begin
      next_pat = N'($urandom);
      @(negedge clk);
    end
    check_ctrs("R10 idle");

    do_clear();

    // Random loads and captures.
    for (int it = 0; it < 25; it++) begin
      do_load(N'($urandom));
      do_capture(N'($urandom));
    end

    // Saturation corner.
    do_clear();
    for (int it = 0; it < 10; it++) begin
      do_load(8'b1010_1010);
      do_load(8'b0101_0101);
    end
    check("R8 shin saturates", int'(shin_cnt), MAXC);
    check("R8 total saturates", int'(total_cnt), MAXC);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL timeout R9 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule